// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a warp's load stage and the global-memory request path. It takes the byte addresses of all lanes of one warp load, together with a mask of active lanes. It works out which aligned 128-byte segments the active lanes touch, and it issues one transfer request per distinct segment. Requests go out one per cycle over a valid/ready handshake. The cost of a warp load in transfers therefore follows its access pattern. A load whose lanes read consecutive words costs one or two transfers. A scattered load costs up to one transfer per lane.

A warp request is accepted only while the block is idle. The block holds `busy` high from acceptance until it returns to idle. After the last segment has been handed over, a one-cycle `done` pulse presents the number of transfers the warp needed. Data return, caching and stores are handled elsewhere.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `busy`, `seg_valid` and `done` are all low.
- R2: `req_valid` is taken only while `busy` is low. A request presented while `busy` is high changes neither the segments issued nor the count reported for the warp in flight.
- R3: Each issued `seg_addr` is the lane address with its low 7 bits forced to zero. The segment index is address bits [ADDR_W-1:7].
- R4: If every active lane falls in one segment, exactly one transfer is issued and the reported count is 1.
- R5: If the active lanes touch k distinct segments, exactly k transfers are issued and the reported count is k.
- R6: When all 32 lanes are active and each lies in a different segment, 32 transfers are issued and the count is 32.
- R7: Lanes whose `req_mask` bit is 0 (bit i belongs to lane i) contribute no segment. An all-zero mask issues no transfer and reports a count of 0.
- R8: Segments are issued in order of the lowest-numbered active lane that touches each one. No segment is issued twice within a warp.
- R9: While `seg_valid` is high and `seg_ready` is low, `seg_valid` stays high and `seg_addr` holds its value. A transfer is consumed only on a cycle where both are high.
- R10: `done` is high for exactly one cycle, after the final transfer. `seg_count` is valid in that cycle, and `busy` is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Warp request present |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i in bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active-lane mask, bit i for lane i |
| busy | output | 1 | A warp is being processed; new requests are ignored |
| seg_valid | output | 1 | A segment transfer request is offered |
| seg_ready | input | 1 | The memory side takes the offered request |
| seg_addr | output | ADDR_W | Base address of the offered segment |
| done | output | 1 | One-cycle pulse at the end of a warp |
| seg_count | output | $clog2(LANES+1) | Number of transfers issued for the warp |

## Verification
The bench uses the default build: 32 lanes, 32-bit addresses and 128-byte segments. This setting reaches the full 32-transfer worst case and the 6-bit count boundary. Lane addresses are generated from a base, a signed stride and a lane modulus. This covers ascending, descending and wrapping patterns, unaligned addresses and sparse masks. Every other vector runs with `seg_ready` throttled, so the hold behaviour is exercised under each pattern.

// File: rtl/coal_pkg.sv
// Package: shared types of the warp coalescer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package coal_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } coal_state_t;
endpackage

// File: rtl/coal_lane_regs.sv
// Module: coal_lane_regs
// Holds the segment index of every lane and the set of lanes whose segment
// is still waiting to be issued. On load it captures the indices and the
// active mask. On clear it drops every pending lane named in clr_mask.
// Assumes load and clear are never asserted in the same cycle.
module coal_lane_regs #(
    parameter int LANES = 32,
    parameter int IDX_W = 25
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [LANES*IDX_W-1:0] load_idx,
    input  logic [LANES-1:0]       load_mask,
    input  logic                   clr,
    input  logic [LANES-1:0]       clr_mask,
    output logic [LANES*IDX_W-1:0] idx_q,
    output logic [LANES-1:0]       pend_q
);

    // Capture lane segment indices when a warp is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= load_idx;
        end
    end

    // Track lanes whose segment has not yet been handed over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load) begin
            pend_q <= load_mask;
        end else if (clr) begin
            pend_q <= pend_q & ~clr_mask;
        end
    end

endmodule

// File: rtl/coal_first_pick.sv
// Module: coal_first_pick
// Finds the lowest-numbered set bit of a request vector and returns its
// index plus an any-set flag. Purely combinational.
// Assumes LANES >= 2.
module coal_first_pick #(
    parameter int LANES = 32,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] req,
    output logic [SEL_W-1:0] sel,
    output logic             any
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        sel = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (req[i]) begin
                sel = SEL_W'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/coal_seg_match.sv
// Module: coal_seg_match
// Compares every lane's segment index with one reference index and flags
// the lanes that share it. One comparator per lane, built by generate.
// Assumes indices are packed lane 0 in the lowest bits.
module coal_seg_match #(
    parameter int LANES = 32,
    parameter int IDX_W = 25
) (
    input  logic [LANES*IDX_W-1:0] idx,
    input  logic [IDX_W-1:0]       ref_idx,
    output logic [LANES-1:0]       hit
);

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        // Flag lane g when it lies in the reference segment.
        always_comb begin
            hit[g] = (idx[g*IDX_W +: IDX_W] == ref_idx);
        end
    end

endmodule

// File: rtl/warp_coalescer.sv
// Module: warp_coalescer (top)
// Reduces one warp load to one transfer request per distinct aligned
// segment touched by the active lanes. Segments are issued in order of the
// lowest active lane touching each, one per valid/ready handshake, and a
// one-cycle done pulse reports how many were issued.
// Assumes the memory side may hold seg_ready low for any number of cycles.
module warp_coalescer #(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int SEG_LOG2 = 7,
    localparam int IDX_W   = ADDR_W - SEG_LOG2,
    localparam int SEL_W   = $clog2(LANES),
    localparam int CNT_W   = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    busy,
    output logic                    seg_valid,
    input  logic                    seg_ready,
    output logic [ADDR_W-1:0]       seg_addr,
    output logic                    done,
    output logic [CNT_W-1:0]        seg_count
);
    import coal_pkg::*;

    coal_state_t              state_q;
    logic                     accept;
    logic                     fire;
    logic [LANES*IDX_W-1:0]   in_idx;
    logic [LANES*IDX_W-1:0]   idx_q;
    logic [LANES-1:0]         pend_q;
    logic [LANES-1:0]         hit;
    logic [SEL_W-1:0]         sel;
    logic                     any_pend;
    logic [IDX_W-1:0]         cur_idx;
    logic [CNT_W-1:0]         cnt_q;

    for (genvar g = 0; g < LANES; g++) begin : g_idx
        // Drop the in-segment offset bits of lane g.
        always_comb begin
            in_idx[g*IDX_W +: IDX_W] = req_addr[g*ADDR_W + SEG_LOG2 +: IDX_W];
        end
    end

    coal_lane_regs #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_idx  (in_idx),
        .load_mask (req_mask),
        .clr       (fire),
        .clr_mask  (hit),
        .idx_q     (idx_q),
        .pend_q    (pend_q)
    );

    coal_first_pick #(
        .LANES (LANES)
    ) u_pick (
        .req (pend_q),
        .sel (sel),
        .any (any_pend)
    );

    // Select the segment index of the lowest pending lane.
    always_comb begin
        cur_idx = idx_q[sel*IDX_W +: IDX_W];
    end

    coal_seg_match #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) u_match (
        .idx     (idx_q),
        .ref_idx (cur_idx),
        .hit     (hit)
    );

    // Handshake and end-of-warp decode.
    always_comb begin
        busy      = (state_q == ST_ISSUE);
        accept    = req_valid && (state_q == ST_IDLE);
        seg_valid = busy && any_pend;
        fire      = seg_valid && seg_ready;
        done      = busy && !any_pend;
        seg_addr  = {cur_idx, {SEG_LOG2{1'b0}}};
        seg_count = cnt_q;
    end

    // Control state: idle until accepted, issue until nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            state_q <= ST_ISSUE;
        end else if (done) begin
            state_q <= ST_IDLE;
        end
    end

    // Count transfers handed over for the current warp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/coal_checker.sv
// Module: coal_checker
// Protocol and ordering properties of warp_coalescer, bound to the top.
// Assumes the same parameters as the instance it is bound to.
module coal_checker #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic              done,
    input logic [CNT_W-1:0]  seg_count
);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr))); // R9

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!seg_valid && !done)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seg_count <= CNT_W'(LANES))); // R6

    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_ready) |=> !(seg_valid && seg_addr == $past(seg_addr))); // R8

    AST_NO_VALID_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !seg_valid); // R10

endmodule

bind warp_coalescer coal_checker #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
) u_coal_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_addr  (seg_addr),
    .done      (done),
    .seg_count (seg_count)
);

// File: tb/tb_warp_coalescer.sv
`timescale 1ns/1ps
module tb_warp_coalescer;
    localparam int L  = 32;
    localparam int AW = 32;
    localparam int CW = $clog2(L + 1);
    localparam int NV = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [L*AW-1:0] req_addr = '0;
    logic [L-1:0]    req_mask = '0;
    logic            busy;
    logic            seg_valid;
    logic            seg_ready = 1'b0;
    logic [AW-1:0]   seg_addr;
    logic            done;
    logic [CW-1:0]   seg_count;

    warp_coalescer #(.LANES(L), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mask(req_mask), .busy(busy), .seg_valid(seg_valid),
        .seg_ready(seg_ready), .seg_addr(seg_addr), .done(done),
        .seg_count(seg_count)
    );

    always #2.5 clk = ~clk;

    // Vector table: base, signed stride, lane modulus, mask, expected count.
    localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h1040, 32'h2000, 32'h0,
        32'h10000, 32'h3000, 32'h4000, 32'h5000, 32'h6000, 32'h7F00, 32'h12345};
    localparam logic [31:0] V_STRIDE [NV] = '{32'd4, 32'd4, 32'd16, 32'd128,
        32'hFFFFFF80, 32'd128, 32'd128, 32'd256, 32'd4, 32'd0, 32'd100};
    localparam int V_MOD [NV] = '{32, 32, 32, 32, 32, 3, 32, 32, 32, 32, 32};
    localparam logic [31:0] V_MASK [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
        32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000000F, 32'h80000001,
        32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF};
    localparam int V_EXP [NV] = '{1, 2, 4, 32, 32, 3, 4, 2, 0, 1, 25};

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] lane_a [L];
    logic [31:0] exp_seg [L];
    int          exp_n;
    logic [31:0] got_seg [L+1];
    int          got_n;
    int          got_cnt;
    bit          hold_ok;
    bit          low_ok;
    bit          saw_done;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference list of segments in first-touch lane order.
    task automatic model(input logic [31:0] m);
        exp_n = 0;
        for (int i = 0; i < L; i++) begin
            if (m[i]) begin
                logic [31:0] s;
                bit seen;
                s = lane_a[i] & 32'hFFFFFF80;
                seen = 1'b0;
                for (int j = 0; j < exp_n; j++) if (exp_seg[j] == s) seen = 1'b1;
                if (!seen) begin
                    exp_seg[exp_n] = s;
                    exp_n++;
                end
            end
        end
    endtask

    // Present one warp, then collect transfers until done.
    task automatic run_warp(input logic [31:0] m, input bit bp, input bit inject);
        bit prev_stall;
        logic [31:0] prev_addr;
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = lane_a[i];
        req_mask = m;
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            req_addr = {L{32'hABC00000}};
            req_mask = '1;
        end
        got_n = 0; got_cnt = -1; hold_ok = 1'b1; low_ok = 1'b1;
        saw_done = 1'b0; prev_stall = 1'b0; prev_addr = '0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (cyc > 0) @(negedge clk);
            seg_ready = bp ? (cyc % 3 != 0) : 1'b1;
            req_valid = inject;
            #1;
            if (seg_valid) begin
                if (prev_stall && seg_addr != prev_addr) hold_ok = 1'b0;
                if (seg_addr[6:0] != 7'd0) low_ok = 1'b0;
                if (seg_ready && got_n <= L) begin
                    got_seg[got_n] = seg_addr;
                    got_n++;
                end
            end
            prev_stall = seg_valid && !seg_ready;
            prev_addr  = seg_addr;
            if (done) begin
                got_cnt = int'(seg_count);
                saw_done = 1'b1;
                req_valid = 1'b0;
                break;
            end
        end
        seg_ready = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic check_seq(input string req);
        bit ok;
        ok = (got_n == exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) if (got_seg[i] != exp_seg[i]) ok = 1'b0;
        check(ok, req, got_n, exp_n);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(!busy && !seg_valid && !done, "R1 reset outputs", int'({busy, seg_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R4 R5 R6 R7 R8 R3 R9 R10
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < L; i++)
                lane_a[i] = V_BASE[v] + V_STRIDE[v] * 32'(i % V_MOD[v]);
            model(V_MASK[v]);
            run_warp(V_MASK[v], v % 2 == 1, 1'b0);
            check(saw_done && got_cnt == V_EXP[v], "R5 count per distinct segment", got_cnt, V_EXP[v]);
            check_seq("R8 issue order and uniqueness");
            check(low_ok, "R3 segment base alignment", int'(low_ok), 1);
            check(hold_ok, "R9 hold while stalled", int'(hold_ok), 1);
            if (V_EXP[v] == 1) check(got_n == 1, "R4 single segment", got_n, 1);
            if (V_EXP[v] == 32) check(got_n == 32, "R6 worst case", got_n, 32);
            if (V_MASK[v] == 0) check(got_n == 0 && got_cnt == 0, "R7 empty mask", got_n, 0);
            @(negedge clk); #1;
            check(!busy && !done, "R10 idle after done", int'({busy, done}), 0);
        end

        // R7: inactive lanes hold wild addresses that must not appear
        for (int i = 0; i < L; i++) lane_a[i] = (i % 2 == 0) ? 32'h8000 : 32'hF0000000 + 32'(i) * 256;
        model(32'h55555555);
        run_warp(32'h55555555, 1'b0, 1'b0);
        check(got_n == 1 && got_cnt == 1, "R7 inactive lanes ignored", got_cnt, 1);
        check_seq("R7 only active segment issued");

        // R2: requests offered while busy are ignored
        for (int i = 0; i < L; i++) lane_a[i] = 32'h9000 + 32'(i) * 64;
        model('1);
        run_warp('1, 1'b1, 1'b1);
        check(got_cnt == 16, "R2 busy request ignored count", got_cnt, 16);
        check_seq("R2 busy request ignored order");
        @(negedge clk); #1;
        check(!busy, "R2 idle after ignored request", int'(busy), 0);

        // R10: done is a single pulse
        for (int i = 0; i < L; i++) lane_a[i] = 32'hA000;
        model('1);
        run_warp('1, 1'b0, 1'b0);
        @(negedge clk); #1;
        check(!done, "R10 done lasts one cycle", int'(done), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule